// File: doc/BRIEF.md
# Burst Splitter for a DMA Read/Write Master

This block takes one transfer request and cuts it into a series of bursts for a memory-mapped DMA master. A request gives a start byte address and a total number of data beats. The block then presents the bursts one at a time on a valid/ready port. Each burst has a byte address and a beat count. When the last burst has been taken, the block pulses a done flag.

The size of each burst comes from a small set of static configuration inputs:

- A programmed burst length, with an optional eight-times scaling.
- Seven enable bits, one for each power-of-two length from 4 to 256 beats.
- A mixed-burst flag that overrides the enable bits.
- A mode flag that picks between two policies. In the free-length policy a burst may take any length up to the limit. In the fixed-length policy only the enabled lengths may be used.
- An alignment flag. When it is set, the bursts are placed on boundaries that are a multiple of their size.

No burst ever crosses a 4 KB page. Configuration must be held stable while a transfer is in progress. The start address must be a multiple of the beat size in bytes.

Top module: `burst_splitter`

## Requirements
- R1: After reset, req_ready_o is 1, burst_valid_o is 0 and done_o is 0.
- R2: The burst cap is cfg_pbl_i times 8 when cfg_pbl_x8_i is 1, and cfg_pbl_i otherwise. It is limited to 256 beats. A programmed value of 0 counts as 1. No burst is longer than the cap.
- R3: Bit i of cfg_len_en_i enables the length 4<<i (bit 0 is 4 beats, bit 6 is 256 beats). The largest enabled length also caps every burst, in both policies. With no bit enabled the cap is 1.
- R4: When cfg_mixed_i is 1, cfg_len_en_i is ignored and all seven lengths count as enabled.
- R5: When cfg_free_len_i is 1, each burst length is the smallest of four values: the remaining beats, the cap, the beats left to the next 4 KB page, and the alignment limit when aligned mode is on.
- R6: When cfg_free_len_i is 0, each burst is the largest enabled length that fits within the limits of R5. If no enabled length fits, a single-beat burst is issued.
- R7: When cfg_aligned_i is 1, let A be the largest power of two that is not above the cap. No burst runs past the next beat index that is a multiple of A.
- R8: No burst crosses a 4096-byte address boundary.
- R9: While burst_valid_o is 1 and burst_ready_i is 0, the address and length hold steady. Each burst starts at the previous burst's address plus its length times BEAT_BYTES. The lengths add up to the requested beat count. burst_len_o is the beat count itself, from 1 to 256.
- R10: done_o pulses for one cycle in the cycle after the last burst is accepted. A request of zero beats issues no burst, and done_o pulses in the cycle after that request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Block is idle and can accept a request |
| req_addr_i | input | AW | Start byte address, a multiple of BEAT_BYTES |
| req_beats_i | input | CW | Total beats to move |
| cfg_pbl_i | input | 9 | Programmed burst length, 0 to 256 |
| cfg_pbl_x8_i | input | 1 | Scale the programmed length by eight |
| cfg_free_len_i | input | 1 | 1 selects the free-length policy, 0 the fixed-length policy |
| cfg_len_en_i | input | 7 | Enables for the lengths 4, 8, 16, 32, 64, 128 and 256 |
| cfg_mixed_i | input | 1 | Ignore the enables and treat all lengths as enabled |
| cfg_aligned_i | input | 1 | Align bursts to their size |
| burst_valid_o | output | 1 | Burst presented |
| burst_ready_i | input | 1 | Burst accepted |
| burst_addr_o | output | AW | Burst start byte address |
| burst_len_o | output | 9 | Burst length in beats |
| done_o | output | 1 | One-cycle pulse after the last burst |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 16-bit beat count and 8-byte beats. With these values a 4 KB page holds 512 beats. That puts both the full 256-beat burst and page crossings within reach of short transfers. An irregular ready pattern exercises the hold behaviour. Start addresses that are not a multiple of the alignment size drive the shortened first burst and the fall-back to single beats.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned N_LEN     = 7;
  localparam int unsigned LEN_W     = 9;
  localparam int unsigned MAX_BEATS = 256;
  localparam int unsigned PAGE_B    = 4096;

  typedef logic [LEN_W-1:0] blen_t;

  function automatic blen_t len_min(input blen_t a, input blen_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/burst_cfg_resolve.sv
module burst_cfg_resolve
  import burst_pkg::*;
(
  input  logic [8:0]       pbl_i,
  input  logic             pbl_x8_i,
  input  logic             mixed_i,
  input  logic [N_LEN-1:0] len_en_i,
  output logic [N_LEN-1:0] mask_o,
  output blen_t            eff_max_o,
  output blen_t            algn_sz_o
);
  logic [11:0] scaled;
  blen_t       pbl_cap;
  blen_t       top_en;

  assign mask_o = mixed_i ? {N_LEN{1'b1}} : len_en_i;

  always_comb begin
    scaled = pbl_x8_i ? {pbl_i, 3'b000} : {3'b000, pbl_i};
    if (scaled == 12'd0)                pbl_cap = blen_t'(1);
    else if (scaled > 12'(MAX_BEATS))   pbl_cap = blen_t'(MAX_BEATS);
    else                                pbl_cap = scaled[LEN_W-1:0];
  end

  always_comb begin
    top_en = blen_t'(1);
    for (int i = 0; i < N_LEN; i++)
      if (mask_o[i]) top_en = blen_t'(9'd4 << i);
  end

  assign eff_max_o = len_min(pbl_cap, top_en);

  // largest power of two not above the cap
  always_comb begin
    algn_sz_o = blen_t'(1);
    for (int i = 0; i < LEN_W; i++)
      if (eff_max_o[i]) algn_sz_o = blen_t'(9'd1 << i);
  end
endmodule

// File: rtl/burst_len_sel.sv
module burst_len_sel
  import burst_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic [CW-1:0]    rem_i,
  input  logic [11:0]      addr_lo_i,
  input  logic             free_len_i,
  input  logic             aligned_i,
  input  logic [N_LEN-1:0] mask_i,
  input  blen_t            eff_max_i,
  input  blen_t            algn_sz_i,
  output blen_t            len_o
);
  localparam int unsigned BB_LOG = $clog2(BEAT_BYTES);

  logic [12:0]      page_left_b;
  logic [12:0]      page_left;
  blen_t            rem_c, page_c, algn_lim, lim;
  logic [11:0]      beat_idx;
  logic [N_LEN-1:0] fit;

  assign rem_c       = (rem_i > CW'(MAX_BEATS)) ? blen_t'(MAX_BEATS) : rem_i[LEN_W-1:0];
  assign page_left_b = 13'(PAGE_B) - {1'b0, addr_lo_i};
  assign page_left   = page_left_b >> BB_LOG;
  assign page_c      = (page_left > 13'(MAX_BEATS)) ? blen_t'(MAX_BEATS) : page_left[LEN_W-1:0];
  assign beat_idx    = addr_lo_i >> BB_LOG;
  assign algn_lim    = algn_sz_i - (beat_idx[LEN_W-1:0] & (algn_sz_i - blen_t'(1)));

  always_comb begin
    lim = len_min(len_min(rem_c, page_c), eff_max_i);
    if (aligned_i) lim = len_min(lim, algn_lim);
  end

  for (genvar g = 0; g < N_LEN; g++) begin : g_fit
    assign fit[g] = mask_i[g] && (blen_t'(9'd4 << g) <= lim);
  end

  always_comb begin
    if (free_len_i) len_o = lim;
    else begin
      len_o = blen_t'(1);
      for (int i = 0; i < N_LEN; i++)
        if (fit[i]) len_o = blen_t'(9'd4 << i);
    end
  end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
  import burst_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned CW         = 16,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [CW-1:0] req_beats_i,
  input  logic [8:0]    cfg_pbl_i,
  input  logic          cfg_pbl_x8_i,
  input  logic          cfg_free_len_i,
  input  logic [6:0]    cfg_len_en_i,
  input  logic          cfg_mixed_i,
  input  logic          cfg_aligned_i,
  output logic          burst_valid_o,
  input  logic          burst_ready_i,
  output logic [AW-1:0] burst_addr_o,
  output logic [8:0]    burst_len_o,
  output logic          done_o
);
  localparam int unsigned BB_LOG = $clog2(BEAT_BYTES);

  logic             busy_q, done_q;
  logic [AW-1:0]    addr_q;
  logic [CW-1:0]    rem_q;
  logic [N_LEN-1:0] mask;
  blen_t            eff_max, algn_sz, sel_len;

  burst_cfg_resolve u_cfg (
    .pbl_i    (cfg_pbl_i),
    .pbl_x8_i (cfg_pbl_x8_i),
    .mixed_i  (cfg_mixed_i),
    .len_en_i (cfg_len_en_i),
    .mask_o   (mask),
    .eff_max_o(eff_max),
    .algn_sz_o(algn_sz)
  );

  burst_len_sel #(.CW(CW), .BEAT_BYTES(BEAT_BYTES)) u_sel (
    .rem_i     (rem_q),
    .addr_lo_i (addr_q[11:0]),
    .free_len_i(cfg_free_len_i),
    .aligned_i (cfg_aligned_i),
    .mask_i    (mask),
    .eff_max_i (eff_max),
    .algn_sz_i (algn_sz),
    .len_o     (sel_len)
  );

  assign req_ready_o   = ~busy_q;
  assign burst_valid_o = busy_q;
  assign burst_addr_o  = addr_q;
  assign burst_len_o   = sel_len;
  assign done_o        = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          addr_q <= req_addr_i;
          rem_q  <= req_beats_i;
          if (req_beats_i == '0) done_q <= 1'b1;
          else                   busy_q <= 1'b1;
        end
      end else if (burst_ready_i) begin
        addr_q <= addr_q + (AW'(sel_len) << BB_LOG);
        rem_q  <= rem_q - CW'(sel_len);
        if (rem_q == CW'(sel_len)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> req_ready_o && !burst_valid_o && !done_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && !burst_ready_i |=>
      burst_valid_o && $stable(burst_addr_o) && $stable(burst_len_o));

  a_r9_within_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o |-> CW'(burst_len_o) <= rem_q);

  a_r2_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o |-> burst_len_o != 9'd0 && burst_len_o <= eff_max);

  a_r6_fixed_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && !cfg_free_len_i |->
      $countones(burst_len_o) == 1 && burst_len_o != 9'd2);

  a_r7_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && cfg_aligned_i |->
      10'((burst_addr_o[11:0] >> BB_LOG) & 12'(algn_sz - 9'd1)) + 10'(burst_len_o)
        <= 10'(algn_sz));

  a_r8_no_4k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o |->
      14'(burst_addr_o[11:0]) + (14'(burst_len_o) << BB_LOG) <= 14'd4096);

  a_r10_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(burst_valid_o) |-> done_o);
endmodule

// File: tb/tb_burst_splitter.sv
module tb_burst_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int BB = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_beats = '0;
  logic [8:0]    pbl = 9'd32;
  logic          pbl_x8 = 1'b0, free_len = 1'b1, mixed = 1'b1, aligned = 1'b0;
  logic [6:0]    len_en = 7'h7f;
  logic          b_valid, b_ready = 1'b0, done;
  logic [AW-1:0] b_addr;
  logic [8:0]    b_len;

  int n_checks = 0, n_fail = 0;
  string cur_tag = "R1";
  logic [AW+8:0] exp_q[$];
  logic [7:0] lfsr = 8'h5a;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_splitter #(.AW(AW), .CW(CW), .BEAT_BYTES(BB)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_beats_i(req_beats),
    .cfg_pbl_i(pbl), .cfg_pbl_x8_i(pbl_x8), .cfg_free_len_i(free_len),
    .cfg_len_en_i(len_en), .cfg_mixed_i(mixed), .cfg_aligned_i(aligned),
    .burst_valid_o(b_valid), .burst_ready_i(b_ready),
    .burst_addr_o(b_addr), .burst_len_o(b_len), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input string msg,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, msg, act, expv);
    end
  endtask

  // irregular ready pattern, changes just after the edge
  always @(posedge clk) begin
    if (!rst_ni) b_ready <= 1'b0;
    else begin
      lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      b_ready <= lfsr[0] | lfsr[2];
    end
  end

  // monitor: compare accepted bursts against the scoreboard queue
  logic          stall_q = 1'b0;
  logic [AW-1:0] st_addr;
  logic [8:0]    st_len;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (stall_q) begin
        check(b_valid && b_addr == st_addr && b_len == st_len, "R9",
              "burst changed while stalled", longint'(b_len), longint'(st_len));
      end
      stall_q <= b_valid && !b_ready;
      st_addr <= b_addr;
      st_len  <= b_len;
      if (b_valid && b_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected burst len", longint'(b_len), 0);
        end else begin
          logic [AW+8:0] e;
          e = exp_q.pop_front();
          check(b_addr == e[AW+8:9], cur_tag, "burst address",
                longint'(b_addr), longint'(e[AW+8:9]));
          check(b_len == e[8:0], cur_tag, "burst length",
                longint'(b_len), longint'(e[8:0]));
        end
      end
    end
  end

  // reference model built from the requirements
  task automatic build_expect(input longint addr, input int beats);
    int scaled, top, emax, algn, r, lim, t, len;
    logic [6:0] mask;
    longint a;
    scaled = pbl_x8 ? int'(pbl) * 8 : int'(pbl);
    if (scaled == 0) scaled = 1;
    if (scaled > 256) scaled = 256;
    mask = mixed ? 7'h7f : len_en;
    top = 1;
    for (int i = 0; i < 7; i++) if (mask[i]) top = 4 << i;
    emax = (scaled < top) ? scaled : top;
    algn = 1;
    while (algn * 2 <= emax) algn = algn * 2;
    a = addr;
    r = beats;
    while (r > 0) begin
      lim = r;
      t = int'((4096 - (a % 4096)) / BB);
      if (t < lim) lim = t;
      if (emax < lim) lim = emax;
      if (aligned) begin
        t = algn - int'((a / BB) % algn);
        if (t < lim) lim = t;
      end
      if (free_len) len = lim;
      else begin
        len = 1;
        for (int i = 0; i < 7; i++) if (mask[i] && (4 << i) <= lim) len = 4 << i;
      end
      exp_q.push_back({a[AW-1:0], 9'(len)});
      a = a + longint'(len) * BB;
      r = r - len;
    end
  endtask

  task automatic run_xfer(input string tag, input longint addr, input int beats);
    int wait_n;
    cur_tag = tag;
    build_expect(addr, beats);
    @(negedge clk);
    req_addr  = addr[AW-1:0];
    req_beats = CW'(beats);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check(done, tag, "done pulse seen", longint'(done), 1);
    check(exp_q.size() == 0, tag, "bursts left unissued at done",
          longint'(exp_q.size()), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done, "R10", "done longer than one cycle", longint'(done), 0);
  endtask

  task automatic set_cfg(input int p, input bit x8, input bit fl,
                         input logic [6:0] en, input bit mx, input bit al);
    pbl = 9'(p); pbl_x8 = x8; free_len = fl; len_en = en; mixed = mx; aligned = al;
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !b_valid && !done, "R1", "idle state in reset",
          longint'({req_ready, b_valid, done}), 4);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready && !b_valid && !done, "R1", "idle state after reset",
          longint'({req_ready, b_valid, done}), 4);

    set_cfg(16, 0, 1, 7'h00, 1, 0);  run_xfer("R5", 32'h1000, 50);   // 16,16,16,2
    set_cfg(4, 1, 1, 7'h00, 1, 0);   run_xfer("R2", 32'h2000, 70);   // cap 32
    set_cfg(64, 1, 1, 7'h00, 1, 0);  run_xfer("R2", 32'h0, 600);     // cap 256
    set_cfg(0, 0, 1, 7'h00, 1, 0);   run_xfer("R2", 32'h80, 2);      // 0 acts as 1
    set_cfg(32, 0, 1, 7'h00, 1, 0);  run_xfer("R8", 32'h0FC0, 40);   // 8 then 32
    set_cfg(256, 0, 1, 7'h00, 1, 0); run_xfer("R8", 32'h3E00, 300);  // page split
    set_cfg(32, 0, 0, 7'h05, 0, 0);  run_xfer("R6", 32'h4000, 45);   // 16,16,4,4,4,1
    set_cfg(64, 0, 1, 7'h02, 0, 0);  run_xfer("R3", 32'h5000, 20);   // 8,8,4
    set_cfg(32, 0, 0, 7'h00, 0, 0);  run_xfer("R3", 32'h6000, 3);    // singles
    set_cfg(16, 0, 0, 7'h00, 1, 0);  run_xfer("R4", 32'h7000, 37);   // 16,16,4,1
    set_cfg(16, 0, 1, 7'h00, 1, 1);  run_xfer("R7", 32'h28, 40);     // 11,16,13
    set_cfg(32, 0, 0, 7'h7f, 0, 1);  run_xfer("R7", 32'h20, 64);     // 16,8,4,32,4
    set_cfg(12, 0, 1, 7'h00, 1, 1);  run_xfer("R7", 32'h18, 30);     // align 8
    set_cfg(32, 0, 1, 7'h00, 1, 0);  run_xfer("R9", 32'h9000, 200);
    run_xfer("R10", 32'hA000, 0);
    run_xfer("R10", 32'hA000, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule